// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block takes launch requests for thread blocks, one at a time, and places each block on one of several multiprocessors. A request carries a thread count and a per-thread register count. The product of the two is the register claim of the block. The warp claim is the thread count rounded up to whole warps. Each multiprocessor keeps its own ledger: registers in use, warps in use and one slot per resident block. A block is placed only on a unit whose ledger can absorb the whole claim without going over any of the three limits. A register range that has been claimed stays with its block until that block's completion is reported.

Requests arrive on a valid/ready channel. A request is consumed on a cycle where `req_valid` and `req_ready` are both high. In that same cycle the block reports either a placement (`disp_valid` with unit and slot) or a rejection (`rej_valid`). While no unit can take the head request, `req_ready` stays low. The producer must then hold the request unchanged until it is taken. Requests are therefore never reordered. The placement outputs are combinational from the request and the current ledgers. The ledgers and the resident table update at the clock edge that consumes the request.

A completion names a unit and a slot. It returns that slot's registers, warps and slot to the unit at the next edge. A completion and a placement on the same unit in the same cycle are both applied.

Top module: `block_admit_dispatch`

## Requirements
- R1: After reset every bit of `resident` is 0 and `disp_valid` and `rej_valid` are low.
- R2: A request is rejected if its thread count is 0 or above 512, or if its register claim (threads times registers per thread) exceeds 8192. A rejected request is consumed with `req_ready` high and `rej_valid` high, it produces no placement, and `resident` is unchanged.
- R3: A unit accepts a block only if its registers in use plus the block's claim is at most 8192. Three blocks of 256 threads at 10 registers fit on one unit. Only two fit at 11 registers.
- R4: A unit holds at most 8 resident blocks.
- R5: A unit holds at most 24 warps. A block's warp count is its thread count rounded up to a multiple of 32, then divided by 32, so 257 threads count as 9 warps.
- R6: Units are tried in round-robin order. The search starts at the unit after the last one that received a block, and the first unit that fits is chosen. After reset the first unit tried is unit 0.
- R7: While no unit fits the head request, `req_ready` is low and no placement is made.
- R8: A completion for a resident slot clears that slot's bit in `resident` at the next edge and returns its resources to the unit. A completion naming a slot that is not resident has no effect.
- R9: When a completion and a placement hit the same unit in one cycle, both the release and the new claim are applied at that edge.
- R10: A placed block takes the lowest-numbered free slot of its unit. Slot s of unit u is bit u*8+s of `resident`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request is consumed this cycle |
| req_threads | input | 10 | Threads in the block |
| req_rpt | input | 8 | Registers per thread |
| disp_valid | output | 1 | Request placed this cycle |
| disp_unit | output | 2 | Chosen multiprocessor |
| disp_slot | output | 3 | Chosen slot on that unit |
| rej_valid | output | 1 | Request rejected as out of range |
| done_valid | input | 1 | Completion of a resident block |
| done_unit | input | 2 | Unit of the completed block |
| done_slot | input | 3 | Slot of the completed block |
| resident | output | 32 | Resident-block table, one bit per unit slot |

## Verification
The hardest situation to reach is a placement and a completion on the same unit in the same cycle. The effect of a lost claim or a lost release only shows up later, as a wrong admission decision. To reach it, the bench first fills every unit with a large block and then sends a small request together with a completion on unit 0. It then steers warp totals so that a further 8-warp request fits only if the ledger counted both updates wrongly. The warp rounding rule is exposed the same way: a released slot is refilled so that exactly 8 warps stay free, and a 257-thread request must stall.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bad_rr_pick.sv
module bad_rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] fit,
  input  logic [W-1:0] last,
  output logic         any,
  output logic [W-1:0] pick
);
  logic [31:0] t;

  always_comb begin
    any  = 1'b0;
    pick = '0;
    t    = '0;
    for (int k = N; k >= 1; k--) begin
      t = 32'(last) + 32'(k);
      if (t >= 32'(N)) t = t - 32'(N);
      if (fit[t[W-1:0]]) begin
        any  = 1'b1;
        pick = t[W-1:0];
      end
    end
  end
endmodule

// File: rtl/bad_unit_ledger.sv
module bad_unit_ledger #(
  parameter int MAX_BLOCKS = 8,
  parameter int REG_POOL   = 8192,
  parameter int MAX_WARPS  = 24,
  parameter int DEM_W      = 18,
  parameter int WRP_W      = 11,
  parameter int SLOT_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEM_W-1:0]      dem_regs,
  input  logic [WRP_W-1:0]      dem_warps,
  input  logic                  claim,
  input  logic                  rel_valid,
  input  logic [SLOT_W-1:0]     rel_slot,
  output logic                  fit,
  output logic [SLOT_W-1:0]     free_idx,
  output logic [MAX_BLOCKS-1:0] resident
);
  localparam int RS_W = DEM_W + 1;
  localparam int WS_W = WRP_W + 1;

  logic [DEM_W-1:0] regs_used;
  logic [WRP_W-1:0] warps_used;
  logic [DEM_W-1:0] slot_regs  [MAX_BLOCKS];
  logic [WRP_W-1:0] slot_warps [MAX_BLOCKS];
  logic             rel_hit;
  logic [DEM_W-1:0] rel_regs;
  logic [WRP_W-1:0] rel_warps;
  logic [RS_W-1:0]  reg_sum;
  logic [WS_W-1:0]  warp_sum;

  assign rel_hit   = rel_valid && resident[rel_slot];
  assign rel_regs  = rel_hit ? slot_regs[rel_slot]  : '0;
  assign rel_warps = rel_hit ? slot_warps[rel_slot] : '0;
  assign reg_sum   = {1'b0, regs_used} + {1'b0, dem_regs};
  assign warp_sum  = {1'b0, warps_used} + {1'b0, dem_warps};
  assign fit = !(&resident) && (reg_sum <= RS_W'(REG_POOL)) &&
               (warp_sum <= WS_W'(MAX_WARPS));

  always_comb begin
    free_idx = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--)
      if (!resident[i]) free_idx = SLOT_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_used  <= '0;
      warps_used <= '0;
      resident   <= '0;
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        slot_regs[i]  <= '0;
        slot_warps[i] <= '0;
      end
    end else begin
      regs_used  <= regs_used + (claim ? dem_regs : '0) - rel_regs;
      warps_used <= warps_used + (claim ? dem_warps : '0) - rel_warps;
      for (int i = 0; i < MAX_BLOCKS; i++) begin
        if (claim && free_idx == SLOT_W'(i)) begin
          resident[i]   <= 1'b1;
          slot_regs[i]  <= dem_regs;
          slot_warps[i] <= dem_warps;
        end else if (rel_hit && rel_slot == SLOT_W'(i)) begin
          resident[i] <= 1'b0;
        end
      end
    end
  end

  assert_claim_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> fit);
  assert_reg_pool_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regs_used <= DEM_W'(REG_POOL));
  assert_warp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warps_used <= WRP_W'(MAX_WARPS));
  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> !resident[$past(rel_slot)]);
endmodule

// File: rtl/block_admit_dispatch.sv
module block_admit_dispatch
  import blk_admit_pkg::*;
#(
  parameter int NUM_UNITS   = 4,
  parameter int MAX_BLOCKS  = 8,
  parameter int REG_POOL    = 8192,
  parameter int MAX_WARPS   = 24,
  parameter int WARP_SIZE   = 32,
  parameter int MAX_THREADS = 512,
  parameter int RPT_W       = 8,
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int UNIT_W = width_of(NUM_UNITS),
  localparam int SLOT_W = width_of(MAX_BLOCKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [THR_W-1:0]                req_threads,
  input  logic [RPT_W-1:0]                req_rpt,
  output logic                            disp_valid,
  output logic [UNIT_W-1:0]               disp_unit,
  output logic [SLOT_W-1:0]               disp_slot,
  output logic                            rej_valid,
  input  logic                            done_valid,
  input  logic [UNIT_W-1:0]               done_unit,
  input  logic [SLOT_W-1:0]               done_slot,
  output logic [NUM_UNITS*MAX_BLOCKS-1:0] resident
);
  localparam int DEM_W = THR_W + RPT_W;
  localparam int WRP_W = THR_W + 1;
  localparam int WS_SH = $clog2(WARP_SIZE);

  logic [DEM_W-1:0]  dem_regs;
  logic [WRP_W-1:0]  thr_round;
  logic [WRP_W-1:0]  dem_warps;
  logic              legal;
  logic [NUM_UNITS-1:0] unit_fit;
  logic [SLOT_W-1:0] unit_free [NUM_UNITS];
  logic              any_fit;
  logic [UNIT_W-1:0] pick;
  logic [UNIT_W-1:0] last_unit;
  logic              accept;

  assign dem_regs  = DEM_W'(req_threads) * DEM_W'(req_rpt);
  assign thr_round = {1'b0, req_threads} + WRP_W'(WARP_SIZE - 1);
  assign dem_warps = thr_round >> WS_SH;
  assign legal = (req_threads != '0) && (req_threads <= THR_W'(MAX_THREADS)) &&
                 (dem_regs <= DEM_W'(REG_POOL)) && (dem_warps <= WRP_W'(MAX_WARPS));

  bad_rr_pick #(.N(NUM_UNITS), .W(UNIT_W)) u_pick (
    .fit(unit_fit), .last(last_unit), .any(any_fit), .pick(pick)
  );

  assign req_ready  = req_valid && (!legal || any_fit);
  assign accept     = req_valid && req_ready;
  assign disp_valid = accept && legal;
  assign rej_valid  = accept && !legal;
  assign disp_unit  = pick;
  assign disp_slot  = unit_free[pick];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [MAX_BLOCKS-1:0] res_u;
    bad_unit_ledger #(
      .MAX_BLOCKS(MAX_BLOCKS), .REG_POOL(REG_POOL), .MAX_WARPS(MAX_WARPS),
      .DEM_W(DEM_W), .WRP_W(WRP_W), .SLOT_W(SLOT_W)
    ) u_ledger (
      .clk      (clk),
      .rst_n    (rst_n),
      .dem_regs (dem_regs),
      .dem_warps(dem_warps),
      .claim    (disp_valid && pick == UNIT_W'(u)),
      .rel_valid(done_valid && done_unit == UNIT_W'(u)),
      .rel_slot (done_slot),
      .fit      (unit_fit[u]),
      .free_idx (unit_free[u]),
      .resident (res_u)
    );
    assign resident[u*MAX_BLOCKS +: MAX_BLOCKS] = res_u;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_unit <= UNIT_W'(NUM_UNITS - 1);
    else if (disp_valid) last_unit <= pick;
  end

  assert_slot_was_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !resident[int'(disp_unit)*MAX_BLOCKS + int'(disp_slot)]);
  assert_slot_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> resident[int'($past(disp_unit))*MAX_BLOCKS + int'($past(disp_slot))]);
  assert_reject_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_valid && !done_valid) |=> $stable(resident));
  assert_stall_no_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (!disp_valid && !rej_valid));
endmodule

// File: tb/block_admit_dispatch_test.sv
module block_admit_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [9:0]  req_threads = 0;
  logic [7:0]  req_rpt = 0;
  logic        disp_valid;
  logic [1:0]  disp_unit;
  logic [2:0]  disp_slot;
  logic        rej_valid;
  logic        done_valid = 0;
  logic [1:0]  done_unit = 0;
  logic [2:0]  done_slot = 0;
  logic [31:0] resident;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  block_admit_dispatch uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_threads(req_threads), .req_rpt(req_rpt), .disp_valid(disp_valid),
    .disp_unit(disp_unit), .disp_slot(disp_slot), .rej_valid(rej_valid),
    .done_valid(done_valid), .done_unit(done_unit), .done_slot(done_slot),
    .resident(resident)
  );

  // threads, regs per thread, rejected, unit, slot
  localparam int TBL [0:13][0:4] = '{
    '{256, 10, 0, 0, 0}, '{256, 10, 0, 1, 0}, '{256, 10, 0, 2, 0}, '{256, 10, 0, 3, 0},
    '{256, 10, 0, 0, 1}, '{256, 10, 0, 1, 1}, '{256, 10, 0, 2, 1}, '{256, 10, 0, 3, 1},
    '{256, 10, 0, 0, 2}, '{256, 10, 0, 1, 2}, '{256, 10, 0, 2, 2}, '{256, 10, 0, 3, 2},
    '{0,    5, 1, 0, 0}, '{513,  1, 1, 0, 0}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_valid = 0; done_valid = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // one-cycle request; samples handshake at the falling edge
  task automatic send(input int thr, input int rpt, input string req,
                      input int exp_unit, input int exp_slot);
    req_valid = 1; req_threads = 10'(thr); req_rpt = 8'(rpt);
    @(negedge clk);
    chk(req_ready && disp_valid, req, {req_ready, disp_valid}, 3);
    chk(disp_unit == 2'(exp_unit), req, disp_unit, exp_unit);
    chk(disp_slot == 3'(exp_slot), req, disp_slot, exp_slot);
    @(posedge clk); #1 req_valid = 0;
  endtask

  // holds a request for three cycles expecting a stall
  task automatic expect_stall(input int thr, input int rpt, input string req);
    req_valid = 1; req_threads = 10'(thr); req_rpt = 8'(rpt);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!req_ready && !disp_valid, req, {req_ready, disp_valid}, 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic complete(input int u, input int s);
    done_valid = 1; done_unit = 2'(u); done_slot = 3'(s);
    @(posedge clk); #1 done_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(resident == 0, "R1 resident", resident, 0);
    chk(!disp_valid && !rej_valid, "R1 outputs", {disp_valid, rej_valid}, 0);
    @(posedge clk); #1;

    // table walk: R3 claims, R6 round robin, R10 lowest slot, R2 rejects
    for (int i = 0; i < 14; i++) begin
      req_valid = 1; req_threads = 10'(TBL[i][0]); req_rpt = 8'(TBL[i][1]);
      @(negedge clk);
      chk(req_ready, "R6 table ready", req_ready, 1);
      chk(rej_valid == TBL[i][2][0], "R2 table reject", rej_valid, TBL[i][2]);
      if (TBL[i][2] == 0) begin
        chk(disp_valid, "R6 table dispatch", disp_valid, 1);
        chk(disp_unit == 2'(TBL[i][3]), "R6 table unit", disp_unit, TBL[i][3]);
        chk(disp_slot == 3'(TBL[i][4]), "R10 table slot", disp_slot, TBL[i][4]);
      end else begin
        chk(!disp_valid, "R2 reject no dispatch", disp_valid, 0);
      end
      @(posedge clk); #1 req_valid = 0;
    end
    chk(resident == 32'h0707_0707, "R2 table resident", resident, 32'h0707_0707);

    // all units at 24 warps: stall, then a completion opens unit 2 slot 1
    expect_stall(32, 1, "R7 full stall");
    done_valid = 1; done_unit = 2; done_slot = 1;
    @(negedge clk);
    chk(!req_ready, "R8 release not yet visible", req_ready, 0);
    @(posedge clk); #1 done_valid = 0;
    chk(resident[17] == 0, "R8 slot cleared", resident[17], 0);
    @(negedge clk);
    chk(req_ready && disp_valid, "R8 freed dispatch", {req_ready, disp_valid}, 3);
    chk(disp_unit == 2 && disp_slot == 1, "R6 skip to unit 2", {disp_unit, disp_slot}, {2'd2, 3'd1});
    @(posedge clk); #1 req_valid = 0;
    chk(resident == 32'h0707_0707, "R10 slot refilled", resident, 32'h0707_0707);

    // register pool: 11 regs per thread allows two per unit
    do_reset();
    for (int i = 0; i < 8; i++) send(256, 11, "R3 two fit", i % 4, i / 4);
    req_valid = 1; req_threads = 512; req_rpt = 17;
    @(negedge clk);
    chk(req_ready && rej_valid && !disp_valid, "R2 claim over pool", {req_ready, rej_valid, disp_valid}, 6);
    @(posedge clk); #1 req_valid = 0;
    chk(resident == 32'h0303_0303, "R2 resident unchanged", resident, 32'h0303_0303);
    expect_stall(256, 11, "R3 third does not fit");

    // block slot cap
    do_reset();
    for (int i = 0; i < 32; i++) send(32, 1, "R4 slot fill", i % 4, i / 4);
    chk(resident == 32'hFFFF_FFFF, "R4 all slots", resident, 32'hFFFF_FFFF);
    expect_stall(1, 0, "R4 ninth block");

    // warp cap and rounding
    do_reset();
    for (int i = 0; i < 4; i++) send(480, 1, "R5 15 warps", i, 0);
    for (int i = 0; i < 4; i++) send(288, 1, "R5 9 warps fit", i, 1);
    req_valid = 1; req_threads = 1; req_rpt = 1;
    @(negedge clk);
    chk(!req_ready, "R5 warps full", req_ready, 0);
    @(posedge clk); #1;
    complete(1, 1);
    @(negedge clk);
    chk(disp_valid && disp_unit == 1 && disp_slot == 1, "R5 one warp after free",
        {disp_valid, disp_unit, disp_slot}, {1'b1, 2'd1, 3'd1});
    @(posedge clk); #1 req_valid = 0;
    expect_stall(257, 1, "R5 257 threads need 9 warps");

    // simultaneous release and claim on unit 0
    do_reset();
    for (int i = 0; i < 4; i++) send(480, 1, "R9 setup", i, 0);
    req_valid = 1; req_threads = 32; req_rpt = 1;
    done_valid = 1; done_unit = 0; done_slot = 0;
    @(negedge clk);
    chk(disp_valid && disp_unit == 0 && disp_slot == 1, "R9 dispatch with release",
        {disp_valid, disp_unit, disp_slot}, {1'b1, 2'd0, 3'd1});
    @(posedge clk); #1 req_valid = 0; done_valid = 0;
    chk(resident[7:0] == 8'b10, "R9 both applied", resident[7:0], 2);
    send(512, 1, "R9 release counted", 0, 0);
    for (int i = 1; i < 4; i++) send(288, 1, "R9 fill", i, 1);
    complete(3, 5);
    chk(resident == 32'h0303_0303, "R8 idle slot ignored", resident, 32'h0303_0303);
    expect_stall(256, 1, "R9 claim counted");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule